// File: doc/BRIEF.md
# Six-Step Inverter Gate Sequencer

This block commands the six gate inputs of a three-leg voltage source inverter so that the bridge produces three-phase quasi-square voltages. It repeatedly walks through six switching states, and it holds each state for a programmable number of clock cycles. In every state each leg connects its output to either the positive rail or the negative rail. The upper and lower switch of a leg are driven as a complementary pair. Leg B follows leg A two steps later, and leg C follows leg A four steps later, so the three legs sit one third of an electrical cycle apart.

The step interval `step_len` (N) sets the output frequency: one electrical period is 6·N clocks. Whenever a leg changes polarity, both of its switches are first held off for `dead_len` (D) cycles, and only then does the incoming switch turn on. Pulling `en` low, or asserting reset, switches every gate off and returns the sequence to its first state. When `en` rises again, the sequence restarts from the first state, and the dead time is applied from the all-off condition.

Top module: `sixstep_gate_seq`

## Requirements
- R1: `step_idx` takes the values 0..5. The upper switch of a leg is on (`gate_hi` bit 0 = A, bit 1 = B, bit 2 = C) as follows: idx0 A; idx1 A,B; idx2 B; idx3 B,C; idx4 C; idx5 A,C. Every other leg has its lower switch on.
- R2: With `en` high, each step lasts exactly N clock cycles, and the step after 5 is 0. A `step_len` of 0 is treated as 1. After t enabled edges, `step_idx` = floor(t/N) mod 6.
- R3: A leg that is not in dead time has exactly one of its two gates high.
- R4: The upper and lower gates of one leg are never high in the same cycle.
- R5: The gates of a leg follow a change of `step_idx` one cycle later. When that leg's polarity flips and D > 0, both of its gates stay low for exactly D cycles before the new gate rises. With D = 0, the leg swaps directly. A leg whose polarity does not change is not disturbed.
- R6: While reset is asserted or `en` is low (as sampled at a clock edge), all six gates are low and `step_idx` is 0.
- R7: After `en` rises, `step_idx` shows 0 at once. Every gate stays low for the first D enabled cycles. The first-state pattern appears after edge D+1.
- R8: The pattern of leg B equals that of leg A delayed by two steps, and the pattern of leg C equals that of leg A delayed by four steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces all gates off and the state to 0 |
| step_len | input | CNT_W | Clocks per step (N); 0 is treated as 1 |
| dead_len | input | DT_W | Dead-time clocks (D); must be less than N |
| gate_hi | output | 3 | Upper switch commands, bit 0 = leg A |
| gate_lo | output | 3 | Lower switch commands, bit 0 = leg A |
| step_idx | output | 3 | Current switching state 0..5 |

## Verification
A wrong step counter shows up on `step_idx` at the first step boundary, which is at most N cycles after enable. The gate pattern then goes wrong on the following cycle. A leg stuck in dead time, or one that released early, shows on its gate pair within D+1 cycles of any polarity flip. Shoot-through shows on the very cycle it occurs. The bench compares every port on every cycle against a closed-form model indexed by the count of enabled edges, so any divergence is caught within one step.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam int NUM_LEGS  = 3;
  localparam int NUM_STEPS = 6;
  localparam int IDX_W     = 3;

  // Leg A is high in steps 5, 0 and 1; each later leg is leg A delayed by two steps.
  function automatic logic upper_on(input logic [IDX_W-1:0] step, input int leg);
    int s;
    s = (int'(step) + NUM_STEPS * 2 - 2 * leg) % NUM_STEPS;
    return (s == 0) || (s == 1) || (s == 5);
  endfunction

  function automatic logic [IDX_W-1:0] step_after(input logic [IDX_W-1:0] step);
    return (int'(step) >= NUM_STEPS - 1) ? '0 : step + 1'b1;
  endfunction
endpackage

// File: rtl/sixstep_step_timer.sv
module sixstep_step_timer
  import sixstep_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [CNT_W-1:0]     step_len,
  output logic [IDX_W-1:0]     step_idx,
  output logic                 step_adv
);
  logic [CNT_W-1:0] dwell;
  logic [CNT_W-1:0] limit;

  assign limit    = (step_len == '0) ? CNT_W'(1) : step_len;
  assign step_adv = en && (dwell >= limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      dwell    <= '0;
      step_idx <= '0;
    end else if (step_adv) begin
      dwell    <= '0;
      step_idx <= step_after(step_idx);
    end else begin
      dwell    <= dwell + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sixstep_leg.sv
module sixstep_leg
  import sixstep_pkg::*;
#(
  parameter int DT_W = 8,
  parameter int LEG  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] step_idx,
  input  logic [DT_W-1:0]  dead_len,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             settled
);
  logic            want_p;
  logic            cur_p;
  logic [DT_W-1:0] dcnt;

  assign want_p = upper_on(step_idx, LEG);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cur_p   <= upper_on(IDX_W'(0), LEG);
      settled <= 1'b0;
      dcnt    <= '0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else if (want_p != cur_p) begin
      cur_p <= want_p;
      dcnt  <= DT_W'(1);
      if (dead_len == '0) begin
        settled <= 1'b1;
        gate_hi <= want_p;
        gate_lo <= !want_p;
      end else begin
        settled <= 1'b0;
        gate_hi <= 1'b0;
        gate_lo <= 1'b0;
      end
    end else if (!settled) begin
      if (dcnt >= dead_len) begin
        settled <= 1'b1;
        gate_hi <= cur_p;
        gate_lo <= !cur_p;
      end else begin
        dcnt <= dcnt + DT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sixstep_gate_seq.sv
module sixstep_gate_seq
  import sixstep_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] step_len,
  input  logic [DT_W-1:0]  dead_len,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo,
  output logic [2:0]       step_idx
);
  logic                step_adv;
  logic [NUM_LEGS-1:0] leg_settled;

  sixstep_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .step_len (step_len),
    .step_idx (step_idx),
    .step_adv (step_adv)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    sixstep_leg #(.DT_W(DT_W), .LEG(g)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .step_idx (step_idx),
      .dead_len (dead_len),
      .gate_hi  (gate_hi[g]),
      .gate_lo  (gate_lo[g]),
      .settled  (leg_settled[g])
    );
  end
endmodule

// File: rtl/sixstep_gate_seq_chk.sv
module sixstep_gate_seq_chk
  import sixstep_pkg::*;
#(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [DT_W-1:0] dead_len,
  input logic [2:0]      gate_hi,
  input logic [2:0]      gate_lo,
  input logic [2:0]      step_idx,
  input logic            step_adv,
  input logic [2:0]      leg_settled
);
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx < 3'd6);

  p_step_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_adv) |=> step_idx == step_after($past(step_idx)));

  p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step_adv) |=> $stable(step_idx));

  p_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_hi == 3'b000) && (gate_lo == 3'b000) && (step_idx == 3'd0));

  for (genvar g = 0; g < 3; g++) begin : g_leg_chk
    p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[g] && gate_lo[g]));

    p_settled_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      leg_settled[g] |-> (gate_hi[g] ^ gate_lo[g]));

    p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_hi[g]) && dead_len != '0) |-> !gate_lo[g]);
  end
endmodule

bind sixstep_gate_seq sixstep_gate_seq_chk #(.DT_W(DT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .dead_len    (dead_len),
  .gate_hi     (gate_hi),
  .gate_lo     (gate_lo),
  .step_idx    (step_idx),
  .step_adv    (step_adv),
  .leg_settled (leg_settled)
);

// File: tb/sixstep_gate_seq_test.sv
`timescale 1ns/1ps
module sixstep_gate_seq_test;
  localparam int CNT_W = 16;
  localparam int DT_W  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [CNT_W-1:0] step_len = CNT_W'(4);
  logic [DT_W-1:0]  dead_len = '0;
  logic [2:0]       gate_hi, gate_lo, step_idx;

  int vectors = 0;
  int misses  = 0;
  int t       = 0;   // enabled edges since last idle
  int n_eff   = 1;
  int d_cur   = 0;

  always #2 clk = ~clk;

  sixstep_gate_seq #(.CNT_W(CNT_W), .DT_W(DT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .step_len(step_len), .dead_len(dead_len),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .step_idx(step_idx)
  );

  // Leg A upper pattern over steps 0..5, bit k = step k.
  function automatic bit a_upper(int s);
    bit [5:0] tbl = 6'b100011;
    return tbl[s];
  endfunction

  function automatic bit leg_upper(int s, int leg);
    return a_upper((s + 12 - 2 * leg) % 6);
  endfunction

  // Expected {hi,lo} of a leg after t enabled edges.
  function automatic bit [1:0] exp_gates(int te, int leg, int n, int d);
    int u, s, r;
    bit pol, on;
    if (te == 0) return 2'b00;
    u = te - 1;
    s = (u / n) % 6;
    r = u % n;
    pol = leg_upper(s, leg);
    if (u < n) on = (u >= d);
    else on = (pol == leg_upper((s + 5) % 6, leg)) || (r >= d);
    return on ? {pol, !pol} : 2'b00;
  endfunction

  function automatic bit in_gap(int te, int n, int d);
    int u;
    if (te == 0) return 1'b0;
    u = te - 1;
    return (u >= n) && ((u % n) < d);
  endfunction

  task automatic check(string tag, int act, int expv);
    vectors++;
    if (act != expv) begin
      misses++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, expv);
    end
  endtask

  task automatic check_all(bit idle);
    for (int leg = 0; leg < 3; leg++) begin
      bit [1:0] e;
      string tag;
      e = exp_gates(t, leg, n_eff, d_cur);
      if (idle) tag = "R6";
      else if (t <= d_cur + 1 && t <= n_eff) tag = "R7";
      else if (in_gap(t, n_eff, d_cur)) tag = "R5";
      else if (leg == 0) tag = "R1";
      else tag = "R8";
      check(tag, {gate_hi[leg], gate_lo[leg]}, e);
      check("R4", gate_hi[leg] & gate_lo[leg], 0);
      if (e != 2'b00) check("R3", gate_hi[leg] ^ gate_lo[leg], 1);
    end
    check(idle ? "R6" : "R2", step_idx, (t / n_eff) % 6);
  endtask

  task automatic run(int n, int d, int cycles);
    @(negedge clk);
    step_len = CNT_W'(n);
    dead_len = DT_W'(d);
    n_eff = (n == 0) ? 1 : n;
    d_cur = d;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_all(1'b0);
      en = 1'b1;
      @(posedge clk);
      t++;
    end
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      en = 1'b0;
      @(posedge clk);
      t = 0;
      @(negedge clk);
      check_all(1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all(1'b1);                 // R6 reset state
    rst_n = 1'b1;
    idle(2);
    run(3, 0, 40);                   // R1 table, direct swap
    idle(3);
    run(5, 2, 70);                   // R5 dead time
    idle(2);
    run(0, 0, 20);                   // R2 zero interval acts as one
    idle(2);
    run(2, 1, 30);                   // R5 smallest gap
    // R6 reset during a run
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    t = 0;
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b1;
    check_all(1'b1);
    idle(1);
    for (int k = 0; k < 40; k++) begin
      int n, d;
      n = 1 + int'($urandom_range(24));
      d = (n > 1) ? int'($urandom_range(n - 1)) : 0;
      run(n, d, 6 * n * 2 + int'($urandom_range(20)));
      idle(1 + int'($urandom_range(3)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule